// File: doc/BRIEF.md
# Rate-Selected Configuration Image Loader

This block stores one small configuration image for each of four serial line rates. When a start request arrives it latches the 2-bit rate code. The code acts as the select of a multiplexer over the four image memories. The block then streams the chosen image, word by word, into a downstream reconfiguration engine. Each word goes out on a single-cycle write strobe together with its word address.

After the final word has been written, the block waits for the engine to report that it has finished. It then raises its own done output for one cycle and returns to idle with every output at its default value. While a load is running, a fixed 3-bit mode code tells the engine to reconfigure both the channel and the PLL.

A busy input from the engine holds off the next write, and the block keeps address and data steady while it waits. A complete reconfiguration, including the engine's own work, takes roughly 7,800 clock cycles.

Top module: `rcfg_image_loader`

## Requirements
- R1: After reset and while idle, `wr_o`, `addr_o`, `data_o`, `mode_o` and `done_o` are all zero.
- R2: A load starts on a clock edge where `start_i` is high in idle, and `rate_i` is captured on that edge. Code 0 selects the 5.000 GBaud image, 1 the 3.125, 2 the 2.500 and 3 the 1.250. Changes of `rate_i` after that edge do not change the image being sent.
- R3: Each write is a single cycle with `wr_o` high, followed by at least one cycle low. During the high cycle, `data_o` equals word `addr_o` of the selected image.
- R4: Each load writes exactly `IMG_WORDS` words (default 38), with addresses 0, 1, … `IMG_WORDS`-1 in ascending order.
- R5: While `eng_busy_i` is high before a pending write, no write is issued and `addr_o` and `data_o` do not change.
- R6: `mode_o` is 3'b101 from the cycle after the start edge until the done cycle. It is 3'b000 otherwise.
- R7: After the last write, the block waits for `eng_done_i`. `done_o` is high for exactly the one cycle after the edge that sampled `eng_done_i`, and the block is idle with default outputs from the next cycle on.
- R8: `start_i` and `eng_done_i` have no effect while words are still being written.
- R9: With `eng_busy_i` low, the first write happens in the second cycle after the start edge, and later writes follow every two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled in idle |
| rate_i | input | SEL_W | Rate code selecting the image |
| eng_busy_i | input | 1 | Engine busy; holds off the next write |
| eng_done_i | input | 1 | Engine finished reconfiguring |
| wr_o | output | 1 | Write strobe, one word per pulse |
| addr_o | output | ADDR_W | Word address within the image |
| data_o | output | DATA_W | Image word |
| mode_o | output | 3 | Reconfiguration mode, 3'b101 while loading |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the loader with its defaults: 38-word images, a 6-bit address, 16-bit data and a 2-bit rate code. This exercises the full address span up to word 37 and all four images. An engine model in the bench adds about 7,700 cycles of latency after the last write, so the whole sequence falls in the 7,700 to 7,900 cycle window. The engine model also produces a recurring busy pattern and an early done pulse. A second start request and a rate change arrive mid-load, which brings the hold-off and ignore paths within reach.

// File: rtl/rcfg_loader_pkg.sv
package rcfg_loader_pkg;

   typedef enum logic [2:0] {
      LD_IDLE  = 3'd0,
      LD_ISSUE = 3'd1,
      LD_PULSE = 3'd2,
      LD_WAIT  = 3'd3,
      LD_FIN   = 3'd4
   } ld_state_t;

   localparam logic [2:0] MODE_CHAN_PLL = 3'b101;
   localparam logic [2:0] MODE_NONE     = 3'b000;

   // Contents of image img at word idx; a mixing hash keeps images distinct.
   function automatic logic [31:0] img_word(input int unsigned img, input int unsigned idx);
      logic [31:0] v;
      v = (32'(img) * 32'd64 + 32'(idx) + 32'd1) * 32'h9E37_79B1;
      return v ^ (v >> 13) ^ 32'h5A3C_0000;
   endfunction

endpackage

// File: rtl/rcfg_image_rom.sv
module rcfg_image_rom #(
   parameter int IMG_ID    = 0,
   parameter int IMG_WORDS = 38,
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 16
) (
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [IMG_WORDS];

   for (genvar w = 0; w < IMG_WORDS; w++) begin : g_word
      assign mem[w] = DATA_W'(rcfg_loader_pkg::img_word(IMG_ID, w));
   end

   always_comb begin
      if (int'(rd_addr) < IMG_WORDS) rd_data = mem[rd_addr];
      else                           rd_data = '0;
   end
endmodule

// File: rtl/rcfg_addr_ctr.sv
module rcfg_addr_ctr #(
   parameter int IMG_WORDS = 38,
   parameter int ADDR_W    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   output logic [ADDR_W-1:0] cnt,
   output logic              last
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(IMG_WORDS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt <= '0;
      else if (inc)      cnt <= cnt + 1'b1;
   end

   assign last = (cnt == LAST_ADDR);
endmodule

// File: rtl/rcfg_load_fsm.sv
module rcfg_load_fsm
   import rcfg_loader_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic busy,
   input  logic eng_done,
   input  logic last,
   output logic capture,
   output logic clr,
   output logic inc,
   output logic wr,
   output logic addr_en,
   output logic mode_on,
   output logic done
);
   ld_state_t st, st_nx;

   always_ff @(posedge clk) begin
      if (!rst_n) st <= LD_IDLE;
      else        st <= st_nx;
   end

   always_comb begin
      st_nx   = st;
      capture = 1'b0;
      clr     = 1'b0;
      inc     = 1'b0;
      unique case (st)
         LD_IDLE:  if (start) begin
                      capture = 1'b1;
                      clr     = 1'b1;
                      st_nx   = LD_ISSUE;
                   end
         LD_ISSUE: if (!busy) st_nx = LD_PULSE;
         LD_PULSE: if (last) st_nx = LD_WAIT;
                   else begin
                      inc   = 1'b1;
                      st_nx = LD_ISSUE;
                   end
         LD_WAIT:  if (eng_done) st_nx = LD_FIN;
         LD_FIN:   st_nx = LD_IDLE;
         default:  st_nx = LD_IDLE;
      endcase
   end

   assign wr      = (st == LD_PULSE);
   assign addr_en = (st == LD_ISSUE) || (st == LD_PULSE);
   assign mode_on = addr_en || (st == LD_WAIT);
   assign done    = (st == LD_FIN);
endmodule

// File: rtl/rcfg_image_loader.sv
module rcfg_image_loader
   import rcfg_loader_pkg::*;
#(
   parameter int IMG_WORDS = 38,
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 16,
   parameter int SEL_W     = 2,
   parameter bit ONEHOT_MUX = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [SEL_W-1:0]  rate_i,
   input  logic              eng_busy_i,
   input  logic              eng_done_i,
   output logic              wr_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic [2:0]        mode_o,
   output logic              done_o
);
   localparam int N_IMG = 1 << SEL_W;

   if (IMG_WORDS < 1 || IMG_WORDS > (1 << ADDR_W)) begin : g_chk_words
      $error("IMG_WORDS must lie in 1 .. 2**ADDR_W");
   end
   if (DATA_W < 1 || DATA_W > 32) begin : g_chk_data
      $error("DATA_W must lie in 1 .. 32");
   end
   if (SEL_W < 1 || SEL_W > 3) begin : g_chk_sel
      $error("SEL_W must lie in 1 .. 3");
   end

   logic              capture, clr, inc, wr, addr_en, mode_on, done, last;
   logic [ADDR_W-1:0] cnt;
   logic [SEL_W-1:0]  sel_q;
   logic [DATA_W-1:0] img_rd [N_IMG];
   logic [DATA_W-1:0] mux_rd;

   always_ff @(posedge clk) begin
      if (!rst_n)       sel_q <= '0;
      else if (capture) sel_q <= rate_i;
   end

   rcfg_load_fsm u_fsm (
      .clk, .rst_n,
      .start(start_i), .busy(eng_busy_i), .eng_done(eng_done_i), .last,
      .capture, .clr, .inc, .wr, .addr_en, .mode_on, .done
   );

   rcfg_addr_ctr #(.IMG_WORDS(IMG_WORDS), .ADDR_W(ADDR_W)) u_ctr (
      .clk, .rst_n, .clr, .inc, .cnt, .last
   );

   for (genvar i = 0; i < N_IMG; i++) begin : g_img
      rcfg_image_rom #(
         .IMG_ID(i), .IMG_WORDS(IMG_WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
      ) u_rom (
         .rd_addr(cnt),
         .rd_data(img_rd[i])
      );
   end

   if (ONEHOT_MUX) begin : g_mux_andor
      always_comb begin
         mux_rd = '0;
         for (int i = 0; i < N_IMG; i++)
            mux_rd |= img_rd[i] & {DATA_W{sel_q == SEL_W'(i)}};
      end
   end else begin : g_mux_index
      assign mux_rd = img_rd[sel_q];
   end

   assign wr_o   = wr;
   assign addr_o = addr_en ? cnt    : '0;
   assign data_o = addr_en ? mux_rd : '0;
   assign mode_o = mode_on ? MODE_CHAN_PLL : MODE_NONE;
   assign done_o = done;
endmodule

// File: rtl/rcfg_image_loader_chk.sv
module rcfg_image_loader_chk #(
   parameter int IMG_WORDS = 38,
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              eng_busy_i,
   input logic              eng_done_i,
   input logic              wr_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic [DATA_W-1:0] data_o,
   input logic [2:0]        mode_o,
   input logic              done_o
);
   logic [ADDR_W:0] wr_seen;

   always_ff @(posedge clk) begin
      if (!rst_n)              wr_seen <= '0;
      else if (mode_o == 3'b0) wr_seen <= '0;
      else if (wr_o)           wr_seen <= wr_seen + 1'b1;
   end

   AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |=> !wr_o); // R3
   AST_WR_HELD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |-> ($stable(addr_o) && $stable(data_o))); // R3
   AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |-> ({1'b0, addr_o} == wr_seen)); // R4
   AST_WORD_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (int'(wr_seen) == IMG_WORDS)); // R4
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy_i && !wr_o && mode_o == 3'b101) |=> (!wr_o && $stable(addr_o) && $stable(data_o))); // R5
   AST_MODE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |-> (mode_o == 3'b101)); // R6
   AST_DONE_AFTER_ENG: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(eng_done_i)); // R7
   AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !wr_o && addr_o == '0 && data_o == '0 && mode_o == 3'b000)); // R7
endmodule

bind rcfg_image_loader rcfg_image_loader_chk #(
   .IMG_WORDS(IMG_WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk, .rst_n, .eng_busy_i, .eng_done_i, .wr_o, .addr_o, .data_o, .mode_o, .done_o
);

// File: tb/rcfg_image_loader_test.sv
module rcfg_image_loader_test;
   localparam int CLK_PERIOD = 10;
   localparam int LEN        = 38;
   localparam int ENG_LAT    = 7700;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [1:0] rate_i = 2'd0;
   logic       eng_busy_i = 1'b0;
   logic       eng_done_i = 1'b0;
   logic       wr_o, done_o;
   logic [5:0] addr_o;
   logic [15:0] data_o;
   logic [2:0] mode_o;

   int compared = 0, mismatched = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rcfg_image_loader uut (
      .clk, .rst_n, .start_i, .rate_i, .eng_busy_i, .eng_done_i,
      .wr_o, .addr_o, .data_o, .mode_o, .done_o
   );

   // Engine model: counts writes, raises done ENG_LAT cycles after the last one.
   int  wcnt = 0, lat = 0, cyc = 0;
   bit  busy_mode = 0, spur = 0;
   always @(posedge clk) begin
      cyc++;
      eng_busy_i <= busy_mode && ((cyc % 7) < 3);
      eng_done_i <= 1'b0;
      if (wr_o) begin
         wcnt++;
         if (wcnt == LEN) lat = ENG_LAT;
         if (spur && wcnt == 5) eng_done_i <= 1'b1;  // early done, R8
      end
      if (lat > 0) begin
         lat--;
         if (lat == 0) eng_done_i <= 1'b1;
      end
   end

   // Behavioural reference: phase 0 idle, 1 awaiting write, 2 writing, 3 awaiting engine, 4 done.
   int m_phase = 0, m_idx = 0, m_rate = 0;
   always @(posedge clk) begin
      if (!rst_n) m_phase = 0;
      else case (m_phase)
         0: if (start_i) begin m_rate = int'(rate_i); m_idx = 0; m_phase = 1; end
         1: if (!eng_busy_i) m_phase = 2;
         2: if (m_idx == LEN - 1) m_phase = 3; else begin m_idx++; m_phase = 1; end
         3: if (eng_done_i) m_phase = 4;
         default: m_phase = 0;
      endcase
   end

   function automatic logic [15:0] exp_word(int r, int i);
      return 16'(rcfg_loader_pkg::img_word(r, i));
   endfunction

   // Compare all outputs every clock, away from the active edge.
   always @(negedge clk) begin
      if (rst_n) begin
         logic        e_wr, e_done;
         logic [5:0]  e_addr;
         logic [15:0] e_data;
         logic [2:0]  e_mode;
         e_wr   = (m_phase == 2);
         e_done = (m_phase == 4);
         e_addr = (m_phase == 1 || m_phase == 2) ? 6'(m_idx) : 6'd0;
         e_data = (m_phase == 1 || m_phase == 2) ? exp_word(m_rate, m_idx) : 16'd0;
         e_mode = (m_phase >= 1 && m_phase <= 3) ? 3'b101 : 3'b000;
         compared++;
         if (wr_o !== e_wr) begin mismatched++;
            $display("FAIL R3/R5/R9 wr_o: actual %0b expected %0b at %0t", wr_o, e_wr, $time); end
         else if (addr_o !== e_addr) begin mismatched++;
            $display("FAIL R4 addr_o: actual %0d expected %0d at %0t", addr_o, e_addr, $time); end
         else if (data_o !== e_data) begin mismatched++;
            $display("FAIL R2/R3 data_o: actual %h expected %h at %0t", data_o, e_data, $time); end
         else if (mode_o !== e_mode) begin mismatched++;
            $display("FAIL R6 mode_o: actual %b expected %b at %0t", mode_o, e_mode, $time); end
         else if (done_o !== e_done) begin mismatched++;
            $display("FAIL R7 done_o: actual %0b expected %0b at %0t", done_o, e_done, $time); end
      end
   end

   task automatic check(bit ok, string tag, int act, int expv);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic run_load(int rate, bit busy, bit spurious, bit restart, bit timed);
      int n = 0;
      wcnt = 0; busy_mode = busy; spur = spurious;
      @(negedge clk);
      start_i = 1'b1; rate_i = 2'(rate);
      @(negedge clk);
      start_i = 1'b0; rate_i = 2'(~rate);      // R2: later change ignored
      if (restart) begin
         repeat (10) @(negedge clk);
         start_i = 1'b1; rate_i = 2'(3 - rate); // R8: start during load ignored
         repeat (3) @(negedge clk);
         start_i = 1'b0;
         n = 13;
      end
      while (!done_o && n < 20000) begin @(negedge clk); n++; end
      check(done_o === 1'b1, "R7 done seen", int'(done_o), 1);
      check(wcnt == LEN, "R4 write count", wcnt, LEN);
      if (timed)
         check(n >= 7700 && n <= 7900, "R7 total cycles in 7700..7900", n, 7800);
      @(negedge clk);
      check(mode_o == 3'b000 && !done_o && addr_o == 6'd0, "R1 idle after done",
            int'(mode_o), 0);
      busy_mode = 0; spur = 0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!wr_o && addr_o == 6'd0 && data_o == 16'd0 && mode_o == 3'b000 && !done_o,
            "R1 reset outputs", int'(wr_o) + int'(mode_o) + int'(done_o), 0);
      for (int r = 0; r < 4; r++) run_load(r, 0, 0, 0, 1);  // R2 each image, R9 spacing
      run_load(2, 1, 0, 0, 0);                              // R5 busy hold-off
      run_load(1, 0, 1, 1, 0);                              // R8 early done and restart
      run_load(3, 1, 1, 0, 0);                              // R5 and R8 together
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule